// File: doc/BRIEF.md
# Multi-Node Interrupt Status Register

This block is the 32-bit status word that a processor reads to find out why a shared interrupt line was raised on a board with four processing nodes (A, B, C, D). It combines three kinds of status bits. Four user-interrupt bits follow the level of interrupt-request registers that other processors set. Four bus-error flags latch when a node's last bus cycle to the bus bridge ends in error. The low nibble shows a vector-acknowledge flag and a 3-bit active-low interrupt priority level, both taken from the bridge.

The user-interrupt levels and the bridge's vector and priority lines are asynchronous to the register clock, so they pass through a synchroniser of `SYNC_STAGES` flops. Bus-error events arrive as single-cycle pulses in the clock domain. Software clears a bus-error flag by writing a one to its bit position. The user-interrupt bits are not cleared by writes: they drop when their source register is cleared. One registered output, `irq_o`, is the OR of every user-interrupt bit and every bus-error flag.

Top module: `node_irq_status`

## Requirements
- R1: Bits 31 to 12 of `rd_data` always read zero.
- R2: Bit 8+i of `rd_data` (i = 0 for node A, 1 for B, 2 for C, 3 for D) equals `node_req_i[i]` delayed by `SYNC_STAGES` clock edges. A write does not change it.
- R3: Bit 4+i of `rd_data` (i = 0 for node A up to 3 for D) is the bus-error flag of node i. It reads one from the clock edge at which `bus_err_i[i]` is sampled high.
- R4: A write (`wr_en` high) clears every bus-error flag whose bit in `wr_data[7:4]` is one, in the same edge. Bits written as zero leave their flags unchanged, and any combination of the four bits may be written at once.
- R5: When a bus-error pulse and a clearing write reach the same flag in the same cycle, the flag ends set.
- R6: While `rst_n` is low, `rd_data` reads zero and `irq_o` is low. All bus-error flags are clear after reset.
- R7: Bit 3 of `rd_data` equals `vec_ack_i`, and bits 2 to 0 equal `ipl_n_i[2:0]` (bit 2 is the most significant). Both are delayed by `SYNC_STAGES` edges. Writes to these bits have no effect.
- R8: `irq_o` is high exactly one cycle after any user-interrupt bit or bus-error flag reads one. It falls in the cycle after the last of them clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data; only bits 7 to 4 have an effect (write one to clear) |
| rd_data | output | 32 | Current status word |
| node_req_i | input | 4 | Asynchronous user-interrupt request levels, bit i = node i (A = 0) |
| bus_err_i | input | 4 | Single-cycle bus-error event per node, bit i = node i |
| vec_ack_i | input | 1 | Asynchronous vector-acknowledge status from the bridge |
| ipl_n_i | input | 3 | Asynchronous active-low interrupt priority level from the bridge |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. With that setting every input pattern takes a known two-edge path to the read port. This makes it practical to sweep all 16 user-request patterns and all 16 vector/priority patterns. It also sweeps all 256 pairs of bus-error pattern and clear mask, both in separate cycles and in the same cycle. Each expected value is computed from the mask arithmetic in the bench, together with the matching `irq_o` level one cycle later.

// File: rtl/nis_pkg.sv
package nis_pkg;
  localparam int REG_W    = 32;
  localparam int NODES    = 4;
  localparam int IPL_W    = 3;
  localparam int ERR_LSB  = 4;
  localparam int USR_LSB  = ERR_LSB + NODES;
  localparam int VACK_BIT = IPL_W;
  localparam int USED_W   = USR_LSB + NODES;
  localparam int PAD_W    = REG_W - USED_W;
  localparam int ASYNC_W  = NODES + 1 + IPL_W;
endpackage

// File: rtl/nis_sync.sv
module nis_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_n;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_n[s] = d_i;
      end else begin : g_rest
        always_comb stage_n[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_n;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nis_err_flags.sv
module nis_err_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] err_evt,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_n;
  logic [N-1:0] flag_en;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_comb begin
        flag_en[i] = err_evt[i] | (wr_en & clr_mask[i]);
        flag_n[i]  = err_evt[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q[i] <= 1'b0;
        else if (flag_en[i]) flag_q[i] <= flag_n[i];
      end

      assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[i] |=> flag_q[i]);
      assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt[i] && wr_en && clr_mask[i]) |=> flag_q[i]);
      assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_mask[i] && !err_evt[i]) |=> !flag_q[i]);
      assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_evt[i] && !(wr_en && clr_mask[i])) |=> $stable(flag_q[i]));
    end
  endgenerate
endmodule

// File: rtl/nis_irq_out.sv
module nis_irq_out #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  output logic             irq_o
);
  logic irq_n;
  logic irq_q;

  always_comb irq_n = |src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq_o = irq_q;

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> irq_o);
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |=> !irq_o);
endmodule

// File: rtl/node_irq_status.sv
module node_irq_status
  import nis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NODES-1:0]  node_req_i,
  input  logic [NODES-1:0]  bus_err_i,
  input  logic              vec_ack_i,
  input  logic [IPL_W-1:0]  ipl_n_i,
  output logic              irq_o
);
  logic [ASYNC_W-1:0] async_s;
  logic [NODES-1:0]   usr_s;
  logic               vack_s;
  logic [IPL_W-1:0]   ipl_s;
  logic [NODES-1:0]   err_q;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:USR_LSB], wr_data[ERR_LSB-1:0]};

  nis_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({node_req_i, vec_ack_i, ipl_n_i}),
    .q_o   (async_s)
  );

  assign {usr_s, vack_s, ipl_s} = async_s;

  nis_err_flags #(.N(NODES)) flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .clr_mask (wr_data[USR_LSB-1:ERR_LSB]),
    .err_evt  (bus_err_i),
    .flag_q   (err_q)
  );

  nis_irq_out #(.SRC_W(2*NODES)) irq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i ({usr_s, err_q}),
    .irq_o (irq_o)
  );

  assign rd_data = {{PAD_W{1'b0}}, usr_s, err_q, vack_s, ipl_s};

  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |-> (rd_data == '0 && !irq_o));
  assert_irq_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[USED_W-1:ERR_LSB] != '0) |=> irq_o);
endmodule

// File: tb/node_irq_status_tb_top.sv
`timescale 1ns/1ps
module node_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  node_req_i;
  logic [3:0]  bus_err_i;
  logic        vec_ack_i;
  logic [2:0]  ipl_n_i;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  node_irq_status #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .node_req_i(node_req_i), .bus_err_i(bus_err_i),
    .vec_ack_i(vec_ack_i), .ipl_n_i(ipl_n_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; node_req_i = '0;
    bus_err_i = '0; vec_ack_i = 1'b0; ipl_n_i = 3'b111;
    repeat (3) step();
    chk("R6 reset rd_data", rd_data, 32'h0);
    chk("R6 reset irq", {31'b0, irq_o}, 32'h0);
    ipl_n_i = 3'b000;
    rst_n = 1'b1;
    repeat (3) step();

    // R2 / R1 / R8: all user request patterns
    for (int p = 0; p < 16; p++) begin
      node_req_i = p[3:0];
      repeat (2) step();
      chk("R2 user bits", {28'b0, rd_data[11:8]}, p);
      chk("R1 reserved zero", {12'b0, rd_data[31:12]}, 32'h0);
      step();
      chk("R8 irq from user", {31'b0, irq_o}, {31'b0, p != 0});
      wr(32'hFFFF_FF0F);
      chk("R2 write ignored", {28'b0, rd_data[11:8]}, p);
      chk("R4 zero mask keeps flags", {28'b0, rd_data[7:4]}, 32'h0);
    end
    node_req_i = '0;
    repeat (3) step();
    chk("R8 irq idle", {31'b0, irq_o}, 32'h0);

    // R7: all vector-ack / priority patterns
    for (int v = 0; v < 16; v++) begin
      vec_ack_i = v[3]; ipl_n_i = v[2:0];
      repeat (2) step();
      chk("R7 low nibble", {28'b0, rd_data[3:0]}, v);
      wr({28'b0, ~v[3:0]});
      chk("R7 write ignored", {28'b0, rd_data[3:0]}, v);
      chk("R8 low nibble no irq", {31'b0, irq_o}, 32'h0);
    end

    // R3 / R4 / R8: set pattern then clear mask
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        bus_err_i = s[3:0];
        step();
        bus_err_i = '0;
        chk("R3 error latch", {28'b0, rd_data[7:4]}, s);
        step();
        chk("R8 irq from error", {31'b0, irq_o}, {31'b0, s != 0});
        wr({24'hFFFFFF, m[3:0], 4'hF});
        chk("R4 w1c mask", {28'b0, rd_data[7:4]}, s & ~m);
        step();
        chk("R8 irq after clear", {31'b0, irq_o}, {31'b0, (s & ~m) != 0});
        wr(32'h0000_00F0);
      end
    end

    // R5: event and clear in the same cycle, starting from all set
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        bus_err_i = 4'hF;
        step();
        bus_err_i = s[3:0];
        wr({24'h0, m[3:0], 4'h0});
        bus_err_i = '0;
        chk("R5 set wins", {28'b0, rd_data[7:4]}, (4'hF & ~m) | s);
        wr(32'h0000_00F0);
      end
    end

    // R6: reset clears latched flags
    bus_err_i = 4'hF; node_req_i = 4'h5;
    step();
    bus_err_i = '0;
    chk("R3 pre-reset flags", {28'b0, rd_data[7:4]}, 32'hF);
    rst_n = 1'b0;
    #1;
    chk("R6 async reset rd_data", rd_data, 32'h0);
    chk("R6 async reset irq", {31'b0, irq_o}, 32'h0);
    node_req_i = '0; ipl_n_i = '0; vec_ack_i = 1'b0;
    step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("R6 flags clear after reset", rd_data, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule